// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Byte Loads

This block sits between a load unit and a small byte-addressable backing memory of 256 bytes, stored little-endian. It keeps four lines, each holding a single 32-bit word together with a valid flag and a tag. A load is either a full word or a single byte that is zero-extended to 32 bits. Each access reports whether it hit or missed. On a miss the block reads the aligned word from memory, writes it into the line the address maps to, and then returns the result.

Memory access is a one-word read with a one-cycle acknowledge. The cache raises busy while a fill is pending, and accepts a new request only while busy is low. A constant output gives the total number of storage bits the line array needs.

Top module: `dm_byte_cache`

## Requirements
- R1: After reset every line is invalid, busy, resp_done and mem_rd are low, and the first access to any index misses.
- R2: An 8-bit address splits into a tag in bits 7:4, a line index in bits 3:2 and a byte offset in bits 1:0. Two addresses that differ only in their offset share one line.
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. A hit raises resp_done with resp_hit high in the cycle after the request, and issues no memory read.
- R4: A miss raises busy and issues exactly one mem_rd pulse with mem_addr equal to the request address with bits 1:0 cleared. The result is returned three cycles after the request, when memory acknowledges in the cycle after mem_rd.
- R5: On the acknowledge the fetched word is written into the indexed line, so that an immediate repeat of the same access hits.
- R6: A miss whose tag differs from the stored tag at the same index replaces that line, and the old address then misses.
- R7: A word load (req_byte = 0) returns the whole stored word on resp_data.
- R8: A byte load (req_byte = 1) returns the byte at offset k from data bits 8k+7:8k, so offset 0 gives bits 7:0 and offset 3 gives bits 31:24. The result is placed in resp_data bits 7:0 with bits 31:8 zero.
- R9: A word load with a non-zero offset raises resp_err together with resp_done in the next cycle. It reads no memory, returns zero data with resp_hit low, and leaves every line unchanged.
- R10: storage_bits reports (tag + valid + data) bits times line count, which is 148 for the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request, taken when busy is low |
| req_byte | input | 1 | 1 = zero-extended byte load, 0 = word load |
| req_addr | input | 8 | Byte address of the load |
| busy | output | 1 | Fill in progress |
| resp_done | output | 1 | One-cycle result strobe |
| resp_hit | output | 1 | Access hit (valid with resp_done) |
| resp_err | output | 1 | Misaligned word load (valid with resp_done) |
| resp_data | output | 32 | Load result |
| mem_rd | output | 1 | Backing memory read pulse |
| mem_addr | output | 8 | Word-aligned read address |
| mem_ack | input | 1 | Read data valid |
| mem_data | input | 32 | Read word |
| storage_bits | output | 16 | Total bits of line storage |

## Verification
The bench uses the default parameters: four lines, 8-bit addresses and 32-bit words. At this size the whole 256-byte space can be swept, so every tag is placed at every index and every byte lane is read. The sweep visits addresses in a scrambled order and alternates word and byte loads. This produces conflict evictions, repeat hits and misaligned loads against both filled and empty lines. A behavioural model of the line array predicts hit, data, error, read count and latency for each access.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/dmc_lane_pick.sv
module dmc_lane_pick #(
  parameter int WORD_W = 32,
  parameter int OFS_W  = 2
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              is_byte,
  output logic [WORD_W-1:0] result
);
  localparam int LANES = WORD_W / 8;

  logic [7:0] lane [LANES];

  // slice the word into byte lanes, lowest address in the low bits
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_in[8*g +: 8];
  end

  always_comb begin
    result = '0;
    if (is_byte) begin
      result[7:0] = lane[ofs];
    end else begin
      result = word_in;
    end
  end
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [WORD_W-1:0] wr_word
);
  logic [LINES-1:0]  valid_vec;
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [WORD_W-1:0] word_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              sel;
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [WORD_W-1:0] w_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        t_q <= wr_tag;
        w_q <= wr_word;
      end
    end

    assign valid_vec[g] = v_q;
    assign tag_arr[g]   = t_q;
    assign word_arr[g]  = w_q;
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_tag   = tag_arr[rd_idx];
  assign rd_word  = word_arr[rd_idx];

  // R5: a written line reads back valid with the tag it was given
  a_r5_line_installed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_vec[$past(wr_idx)] && (tag_arr[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              look_valid,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic [WORD_W-1:0] lane_result,
  input  logic              mem_ack,
  output logic              busy,
  output logic              fill_sel,
  output logic [OFS_W-1:0]  lane_ofs,
  output logic              lane_byte,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic              resp_done,
  output logic              resp_hit,
  output logic              resp_err,
  output logic              resp_is_byte,
  output logic [WORD_W-1:0] resp_data
);
  ctl_state_e state_q, state_d;

  logic [ADDR_W-1:0] lat_addr_q, lat_addr_d;
  logic              lat_byte_q, lat_byte_d;
  logic              lat_en;

  logic              done_d, hit_d, err_d, isbyte_d;
  logic [WORD_W-1:0] data_d;

  logic [OFS_W-1:0]  req_ofs;
  logic [TAG_W-1:0]  req_tag;
  logic              misalign;
  logic              tag_match;

  assign req_ofs   = req_addr[OFS_W-1:0];
  assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
  assign misalign  = !req_byte && (req_ofs != '0);
  assign tag_match = look_valid && (look_tag == req_tag);

  // next-state and response selection
  always_comb begin
    state_d    = state_q;
    lat_en     = 1'b0;
    lat_addr_d = req_addr;
    lat_byte_d = req_byte;
    done_d     = 1'b0;
    hit_d      = 1'b0;
    err_d      = 1'b0;
    isbyte_d   = resp_is_byte;
    data_d     = '0;
    wr_en      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (misalign) begin
            done_d   = 1'b1;
            err_d    = 1'b1;
            isbyte_d = 1'b0;
          end else if (tag_match) begin
            done_d   = 1'b1;
            hit_d    = 1'b1;
            isbyte_d = req_byte;
            data_d   = lane_result;
          end else begin
            lat_en  = 1'b1;
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_ack) begin
          wr_en    = 1'b1;
          done_d   = 1'b1;
          isbyte_d = lat_byte_q;
          data_d   = lane_result;
          state_d  = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      resp_done    <= 1'b0;
      resp_hit     <= 1'b0;
      resp_err     <= 1'b0;
      resp_is_byte <= 1'b0;
      resp_data    <= '0;
    end else begin
      state_q      <= state_d;
      resp_done    <= done_d;
      resp_hit     <= hit_d;
      resp_err     <= err_d;
      resp_is_byte <= isbyte_d;
      resp_data    <= data_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lat_en) begin
      lat_addr_q <= lat_addr_d;
      lat_byte_q <= lat_byte_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign fill_sel  = (state_q == ST_WAIT);
  assign lane_ofs  = fill_sel ? lat_addr_q[OFS_W-1:0] : req_ofs;
  assign lane_byte = fill_sel ? lat_byte_q : req_byte;
  assign mem_rd    = (state_q == ST_FETCH);
  assign mem_addr  = {lat_addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign wr_idx    = lat_addr_q[OFS_W +: IDX_W];
  assign wr_tag    = lat_addr_q[ADDR_W-1 -: TAG_W];

  // R4: the read strobe lasts a single cycle and the fill stays pending after it
  a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd && busy);

  // R9: an error result never carries a hit or data
  a_r9_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_done && !resp_hit && (resp_data == '0));
endmodule

// File: rtl/dm_byte_cache.sv
module dm_byte_cache #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              resp_done,
  output logic              resp_hit,
  output logic              resp_err,
  output logic [WORD_W-1:0] resp_data,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_data,
  output logic [15:0]       storage_bits
);
  localparam int OFS_W      = $clog2(WORD_W / 8);
  localparam int IDX_W      = $clog2(LINES);
  localparam int TAG_W      = ADDR_W - IDX_W - OFS_W;
  localparam int STORE_BITS = (TAG_W + 1 + WORD_W) * LINES;

  // asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              look_valid;
  logic [TAG_W-1:0]  look_tag;
  logic [WORD_W-1:0] look_word;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic              fill_sel;
  logic [OFS_W-1:0]  lane_ofs;
  logic              lane_byte;
  logic [WORD_W-1:0] lane_word;
  logic [WORD_W-1:0] lane_result;
  logic              resp_is_byte;

  dmc_tag_store #(
    .LINES (LINES),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .WORD_W(WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_idx  (req_addr[OFS_W +: IDX_W]),
    .rd_valid(look_valid),
    .rd_tag  (look_tag),
    .rd_word (look_word),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tag  (wr_tag),
    .wr_word (mem_data)
  );

  assign lane_word = fill_sel ? mem_data : look_word;

  dmc_lane_pick #(
    .WORD_W(WORD_W),
    .OFS_W (OFS_W)
  ) u_lane (
    .word_in(lane_word),
    .ofs    (lane_ofs),
    .is_byte(lane_byte),
    .result (lane_result)
  );

  dmc_ctrl #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .OFS_W (OFS_W),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .req_byte    (req_byte),
    .req_addr    (req_addr),
    .look_valid  (look_valid),
    .look_tag    (look_tag),
    .lane_result (lane_result),
    .mem_ack     (mem_ack),
    .busy        (busy),
    .fill_sel    (fill_sel),
    .lane_ofs    (lane_ofs),
    .lane_byte   (lane_byte),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_tag      (wr_tag),
    .resp_done   (resp_done),
    .resp_hit    (resp_hit),
    .resp_err    (resp_err),
    .resp_is_byte(resp_is_byte),
    .resp_data   (resp_data)
  );

  assign storage_bits = 16'(STORE_BITS);

  // R8: a byte result never has upper bits set
  a_r8_upper_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resp_done && resp_is_byte |-> (resp_data[WORD_W-1:8] == '0));

  // R3: an aligned request that finds a matching valid line completes as a hit next cycle
  a_r3_hit_next: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && req_valid && (req_byte || req_addr[OFS_W-1:0] == '0) && look_valid &&
     look_tag == req_addr[ADDR_W-1 -: TAG_W]) |=> resp_done && resp_hit && !mem_rd);

  // R4: memory acknowledges only arrive while a fill is pending
  a_r4_ack_in_fill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_ack |-> busy && !mem_rd);
endmodule

// File: tb/dm_byte_cache_test.sv
module dm_byte_cache_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_byte = 1'b0;
  logic [7:0]  req_addr = '0;
  logic        busy, resp_done, resp_hit, resp_err, mem_rd;
  logic [31:0] resp_data;
  logic [7:0]  mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_data = '0;
  logic [15:0] storage_bits;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem_word [64];
  bit          m_valid [4];
  logic [3:0]  m_tag [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_byte_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_byte(req_byte),
    .req_addr(req_addr), .busy(busy), .resp_done(resp_done), .resp_hit(resp_hit),
    .resp_err(resp_err), .resp_data(resp_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_data(mem_data), .storage_bits(storage_bits)
  );

  // backing memory: synchronous read, acknowledged one cycle after the strobe
  always @(posedge clk) begin
    mem_ack  <= mem_rd;
    mem_data <= mem_word[mem_addr[7:2]];
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit is_byte, input logic [7:0] a, input string req);
    logic [1:0]  idx;
    logic [3:0]  tg;
    logic [31:0] w;
    logic [31:0] exp_data;
    bit          exp_err, exp_hit;
    int          lat, reads;
    bit          addr_ok;
    idx = a[3:2];
    tg  = a[7:4];
    w   = mem_word[a[7:2]];
    exp_err  = !is_byte && (a[1:0] != 2'b00);
    exp_hit  = !exp_err && m_valid[idx] && (m_tag[idx] == tg);
    exp_data = exp_err ? 32'h0 : (is_byte ? {24'h0, w[8*a[1:0] +: 8]} : w);

    @(negedge clk);
    req_valid = 1'b1;
    req_byte  = is_byte;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    reads = 0;
    addr_ok = 1'b1;
    while (!resp_done && lat < 40) begin
      if (mem_rd) begin
        reads++;
        if (mem_addr !== {a[7:2], 2'b00}) addr_ok = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    if (lat >= 40) begin
      errors++;
      $display("FAIL %s watchdog actual no resp_done expected resp_done", req);
    end
    check(req, "done", 32'(resp_done), 32'd1);
    check(req, "hit", 32'(resp_hit), 32'(exp_hit));
    check(req, "err", 32'(resp_err), 32'(exp_err));
    check(req, "data", resp_data, exp_data);
    check(req, "mem reads", 32'(reads), (exp_hit || exp_err) ? 32'd0 : 32'd1);
    check(req, "latency", 32'(lat), (exp_hit || exp_err) ? 32'd1 : 32'd3);
    check(req, "read addr aligned", 32'(addr_ok), 32'd1);
    if (!exp_hit && !exp_err) begin
      m_valid[idx] = 1'b1;
      m_tag[idx]   = tg;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) begin
      for (int b = 0; b < 4; b++) begin
        mem_word[k][8*b +: 8] = 8'((4*k + b) * 37 + 11);
      end
    end
    for (int i = 0; i < 4; i++) begin
      m_valid[i] = 1'b0;
      m_tag[i]   = '0;
    end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs after reset
    check("R1", "busy", 32'(busy), 32'd0);
    check("R1", "resp_done", 32'(resp_done), 32'd0);
    check("R1", "mem_rd", 32'(mem_rd), 32'd0);
    // R10: storage size
    check("R10", "storage_bits", 32'(storage_bits), 32'd148);

    access(1'b1, 8'h13, "R1");   // first touch of index 0 misses, offset 3
    access(1'b1, 8'h10, "R8");   // offset 0, hit
    access(1'b1, 8'h11, "R8");
    access(1'b1, 8'h12, "R2");   // same line, other offset
    access(1'b0, 8'h10, "R7");   // word hit
    access(1'b0, 8'h2C, "R4");   // word miss at index 3
    access(1'b0, 8'h2C, "R5");   // repeat hits
    access(1'b0, 8'h2E, "R9");   // misaligned
    access(1'b0, 8'h2C, "R9");   // line unchanged, still hits
    access(1'b0, 8'h05, "R9");   // misaligned on an empty line
    access(1'b1, 8'h05, "R9");   // still a miss: nothing was installed
    access(1'b1, 8'h9F, "R6");   // conflict at index 3
    access(1'b0, 8'h2C, "R6");   // old tag now misses
    access(1'b1, 8'h9F, "R6");   // and evicts the newer one
    access(1'b0, 8'h20, "R3");   // index 0 with another tag misses
    access(1'b0, 8'h20, "R3");   // then hits

    // R2: sweep the whole address space in scrambled order
    for (int i = 0; i < 256; i++) begin
      access(i[0], 8'(i * 97 + 3), "R2");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule